// File: doc/BRIEF.md
# Stackable SPI Chip-Select Expander

This block lets a host SPI master with only two select lines reach many slave devices spread over a stack of up to four cards. The host uses one select line for addressing. While that line is low, the host shifts in one address byte, and the byte names a card and a device on that card. The host uses the second select line for transfers. Each card forwards this line to the active-low select of the device it has latched, but only when the card field of the byte equals the card's own jumper setting. The selection stays latched, so any number of transfers can follow before the host sends a new address byte.

One device code does not leave the block. It selects an internal 8-bit write register. That register drives four bicolor LEDs through a two-line-per-LED encoding, so the polarity of each LED can be set.

All SPI inputs are brought into the system clock domain through a synchronizer whose depth is a parameter. The SPI format is mode 0: data is sampled on the rising SPI clock, most significant bit first. The port selects and the LED lines leave the block from flops.

Top module: `spi_csx_top`

## Requirements
- R1: After reset, all four port selects are high (deasserted) and every red and green LED line is low (all LEDs off).
- R2: An address byte is shifted in MSB first on rising SPI clock edges while the addressing select is low. It is taken when the addressing select rises. Bits 7:6 of the byte hold the card address, bits 5:3 are ignored, and bits 2:0 hold the device code.
- R3: When the latched card address differs from the jumper input, all port selects stay high and the LED register is not written.
- R4: On a matching card, device codes 1, 2, 3 and 4 drive port_sel_n bit 0, 1, 2 and 3 low respectively while the transfer select is low. No other port select goes low at the same time.
- R5: Device codes 0, 5, 6 and 7 drive no port select low. Code 5 addresses only the internal LED register.
- R6: The latched selection persists across any number of transfer-select assertions.
- R7: A new valid address byte replaces the previous card and device selection.
- R8: An address phase that does not contain exactly 8 rising SPI clock edges is discarded, and the previous selection is kept.
- R9: With code 5 latched on a matching card, a transfer of exactly 8 bits (MSB first) is loaded into the LED register when the transfer select rises. LED n (n = 0 to 3) uses register bits 2n+1:2n. The value 01 lights red (led_red[n]=1), 10 lights green (led_grn[n]=1), and 00 and 11 turn the LED off. A transfer of any other length leaves the register unchanged.
- R10: Every port select returns high once the transfer select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_id | input | 2 | Jumper-set card address of this card |
| sclk | input | 1 | SPI clock from host (mode 0) |
| mosi | input | 1 | SPI data from host |
| addr_sel_n | input | 1 | Active-low addressing select |
| xfer_sel_n | input | 1 | Active-low transfer select |
| port_sel_n | output | 4 | Active-low selects for external ports 1 to 4 |
| led_red | output | 4 | Red drive line of each bicolor LED |
| led_grn | output | 4 | Green drive line of each bicolor LED |

## Verification
The bench sweeps every jumper value against every addressed card and every device code. It varies the ignored middle bits on each step. This separates a correct card comparison and device decode from errors such as swapped fields, an off-by-one port mapping or a decode that depends on the ignored bits. All 256 LED register values are written, which covers each of the four bit-pair codes in every LED position, and each write is checked on both LED lines. Address phases and LED writes of 7 and 9 bits, and LED writes aimed at another card, tell a correct bit-count gate apart from one that commits on any release. Repeated transfers without readdressing confirm that the selection persists.

// File: rtl/spi_csx_pkg.sv
package spi_csx_pkg;
   parameter int unsigned BYTE_BITS   = 8;
   parameter int unsigned CARD_BITS   = 2;
   parameter int unsigned DEV_BITS    = 3;
   parameter int unsigned PORT_COUNT  = 4;
   parameter int unsigned SYNC_DEPTH  = 2;

   typedef enum logic [1:0] {
      LED_DARK0 = 2'b00,
      LED_RED   = 2'b01,
      LED_GREEN = 2'b10,
      LED_DARK1 = 2'b11
   } led_code_e;

   function automatic logic is_red(input logic [1:0] code);
      return led_code_e'(code) == LED_RED;
   endfunction

   function automatic logic is_green(input logic [1:0] code);
      return led_code_e'(code) == LED_GREEN;
   endfunction
endpackage

// File: rtl/spi_csx_sync.sv
module spi_csx_sync #(
   parameter int unsigned W       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= {STAGES{RST_VAL}};
            end else begin
               q[0] <= din;
               for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
            end
         end
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_csx_shreg.sv
module spi_csx_shreg #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              close_stb,
   output logic [BYTE_W-1:0] data_o
);
   localparam int unsigned CNT_W   = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(BYTE_W + 1);

   logic [BYTE_W-1:0] shift_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         cnt_q   <= '0;
         data_o  <= '0;
      end else if (close_stb) begin
         if (cnt_q == FULL) data_o <= shift_q;
         cnt_q <= '0;
      end else if (!active) begin
         cnt_q <= '0;
      end else if (bit_stb) begin
         shift_q <= {shift_q[BYTE_W-2:0], bit_val};
         if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/spi_csx_decode.sv
module spi_csx_decode #(
   parameter int unsigned CARD_W    = 2,
   parameter int unsigned DEV_W     = 3,
   parameter int unsigned NUM_PORTS = 4
) (
   input  logic [CARD_W-1:0]    card_field,
   input  logic [DEV_W-1:0]     dev_field,
   input  logic [CARD_W-1:0]    jumpers,
   output logic                 card_hit,
   output logic [NUM_PORTS-1:0] port_hit,
   output logic                 led_hit
);
   localparam logic [DEV_W-1:0] LED_CODE = DEV_W'(NUM_PORTS + 1);

   assign card_hit = (card_field == jumpers);
   assign led_hit  = (dev_field == LED_CODE);

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         assign port_hit[p] = (dev_field == DEV_W'(p + 1));
      end
   endgenerate
endmodule

// File: rtl/spi_csx_top.sv
module spi_csx_top
   import spi_csx_pkg::*;
#(
   parameter int unsigned BYTE_W      = BYTE_BITS,
   parameter int unsigned CARD_W      = CARD_BITS,
   parameter int unsigned DEV_W       = DEV_BITS,
   parameter int unsigned NUM_PORTS   = PORT_COUNT,
   parameter int unsigned SYNC_STAGES = SYNC_DEPTH,
   localparam int unsigned NUM_LEDS   = BYTE_W / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CARD_W-1:0]    card_id,
   input  logic                 sclk,
   input  logic                 mosi,
   input  logic                 addr_sel_n,
   input  logic                 xfer_sel_n,
   output logic [NUM_PORTS-1:0] port_sel_n,
   output logic [NUM_LEDS-1:0]  led_red,
   output logic [NUM_LEDS-1:0]  led_grn
);
   localparam int unsigned MID_HI = BYTE_W - CARD_W - 1;

   generate
      if (CARD_W + DEV_W > BYTE_W) begin : g_bad_fields
         $error("card and device fields do not fit in the address byte");
      end
      if (NUM_PORTS + 2 > (1 << DEV_W)) begin : g_bad_ports
         $error("device field too narrow for ports plus LED register");
      end
      if ((BYTE_W % 2) != 0) begin : g_bad_led
         $error("LED register width must be even");
      end
   endgenerate

   // synchronized SPI pins: {sclk, mosi, addr_sel_n, xfer_sel_n}
   logic [3:0] pins_s;
   spi_csx_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .din ({sclk, mosi, addr_sel_n, xfer_sel_n}),
      .dout(pins_s)
   );

   logic s_sclk, s_mosi, s_addr, s_xfer;
   assign {s_sclk, s_mosi, s_addr, s_xfer} = pins_s;

   logic p_sclk, p_addr, p_xfer;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_sclk <= 1'b0;
         p_addr <= 1'b1;
         p_xfer <= 1'b1;
      end else begin
         p_sclk <= s_sclk;
         p_addr <= s_addr;
         p_xfer <= s_xfer;
      end
   end

   logic sclk_rise, addr_close, xfer_close;
   assign sclk_rise  = s_sclk & ~p_sclk;
   assign addr_close = s_addr & ~p_addr;
   assign xfer_close = s_xfer & ~p_xfer;

   // address phase
   logic [BYTE_W-1:0] addr_q;
   spi_csx_shreg #(.BYTE_W(BYTE_W)) u_addr (
      .clk (clk), .rst_n (rst_n),
      .active   (~s_addr),
      .bit_stb  (sclk_rise),
      .bit_val  (s_mosi),
      .close_stb(addr_close),
      .data_o   (addr_q)
   );

   logic unused_mid;
   assign unused_mid = ^addr_q[MID_HI:DEV_W];

   logic                 card_hit;
   logic [NUM_PORTS-1:0] port_hit;
   logic                 led_hit;
   spi_csx_decode #(.CARD_W(CARD_W), .DEV_W(DEV_W), .NUM_PORTS(NUM_PORTS)) u_dec (
      .card_field(addr_q[BYTE_W-1 -: CARD_W]),
      .dev_field (addr_q[DEV_W-1:0]),
      .jumpers   (card_id),
      .card_hit  (card_hit),
      .port_hit  (port_hit),
      .led_hit   (led_hit)
   );

   // transfer phase: external port selects
   logic xfer_on;
   assign xfer_on = ~s_xfer & card_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) port_sel_n <= '1;
      else        port_sel_n <= ~({NUM_PORTS{xfer_on}} & port_hit);
   end

   // transfer phase: internal LED register
   logic [BYTE_W-1:0] led_q;
   spi_csx_shreg #(.BYTE_W(BYTE_W)) u_led (
      .clk (clk), .rst_n (rst_n),
      .active   (xfer_on & led_hit),
      .bit_stb  (sclk_rise),
      .bit_val  (s_mosi),
      .close_stb(xfer_close),
      .data_o   (led_q)
   );

   generate
      for (genvar n = 0; n < NUM_LEDS; n++) begin : g_led
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               led_red[n] <= 1'b0;
               led_grn[n] <= 1'b0;
            end else begin
               led_red[n] <= is_red(led_q[2*n+1 -: 2]);
               led_grn[n] <= is_green(led_q[2*n+1 -: 2]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/spi_csx_checker.sv
module spi_csx_checker #(
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned NUM_LEDS    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 xfer_sel_n,
   input logic                 card_hit,
   input logic [NUM_PORTS-1:0] port_sel_n,
   input logic [NUM_LEDS-1:0]  led_red,
   input logic [NUM_LEDS-1:0]  led_grn
);
   localparam int unsigned LIM   = SYNC_STAGES + 3;
   localparam int unsigned CNT_W = $clog2(LIM + 2);

   logic [CNT_W-1:0] idle_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            idle_cnt <= '0;
      else if (!xfer_sel_n)  idle_cnt <= '0;
      else if (idle_cnt != CNT_W'(LIM)) idle_cnt <= idle_cnt + 1'b1;
   end

   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (port_sel_n == '1 && led_red == '0 && led_grn == '0));

   a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~port_sel_n));

   a_r3_foreign_card: assert property (@(posedge clk) disable iff (!rst_n)
      !card_hit |=> (port_sel_n == '1));

   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cnt > CNT_W'(SYNC_STAGES + 1)) |-> (port_sel_n == '1));

   a_r9_led_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (led_red & led_grn) == '0);

   a_r9_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cnt == CNT_W'(LIM)) |=> ($stable(led_red) && $stable(led_grn)));
endmodule

bind spi_csx_top spi_csx_checker #(
   .NUM_PORTS(NUM_PORTS), .NUM_LEDS(NUM_LEDS), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .xfer_sel_n(xfer_sel_n), .card_hit(card_hit),
   .port_sel_n(port_sel_n), .led_red(led_red), .led_grn(led_grn)
);

// File: tb/spi_csx_top_bench.sv
`timescale 1ns/1ps
module spi_csx_top_bench;
   localparam int HP = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] card_id = 2'd0;
   logic       sclk = 1'b0, mosi = 1'b0, addr_sel_n = 1'b1, xfer_sel_n = 1'b1;
   logic [3:0] port_sel_n, led_red, led_grn;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] led_model = 8'h00;

   always #2 clk = ~clk;

   spi_csx_top u_spi_csx_top (
      .clk(clk), .rst_n(rst_n), .card_id(card_id), .sclk(sclk), .mosi(mosi),
      .addr_sel_n(addr_sel_n), .xfer_sel_n(xfer_sel_n),
      .port_sel_n(port_sel_n), .led_red(led_red), .led_grn(led_grn)
   );

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk4(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic shift_bits(input logic [15:0] val, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) begin
         mosi = val[i];
         wt(HP);
         sclk = 1'b1;
         wt(HP);
         sclk = 1'b0;
      end
      wt(HP);
   endtask

   task automatic send_addr(input logic [15:0] val, input int nbits);
      addr_sel_n = 1'b0;
      wt(HP);
      shift_bits(val, nbits);
      addr_sel_n = 1'b1;
      wt(2*HP);
   endtask

   // one transfer; checks port selects during and after
   task automatic xfer(input string req, input logic [3:0] exp_sel,
                       input logic [15:0] val, input int nbits);
      xfer_sel_n = 1'b0;
      wt(HP);
      chk4(req, port_sel_n, exp_sel);
      shift_bits(val, nbits);
      xfer_sel_n = 1'b1;
      wt(2*HP);
      chk4("R10 release", port_sel_n, 4'hF);
   endtask

   function automatic logic [3:0] exp_ports(input int jmp, input int card, input int dev);
      if (card == jmp && dev >= 1 && dev <= 4) return ~(4'b0001 << (dev - 1));
      return 4'hF;
   endfunction

   task automatic chk_leds(input string req);
      logic [3:0] er, eg;
      for (int n = 0; n < 4; n++) begin
         er[n] = (((led_model >> (2*n)) & 8'h3) == 8'h1);
         eg[n] = (((led_model >> (2*n)) & 8'h3) == 8'h2);
      end
      chk4({req, " red"}, led_red, er);
      chk4({req, " green"}, led_grn, eg);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      wt(5);
      rst_n = 1'b1;
      wt(5);
      // R1 reset state
      chk4("R1 port selects", port_sel_n, 4'hF);
      chk4("R1 red", led_red, 4'h0);
      chk4("R1 green", led_grn, 4'h0);
      chk4("R5 nothing before addressing", port_sel_n, 4'hF);

      // R2 R3 R4 R5 R7: sweep jumpers x card x device, ignored bits varied
      for (int j = 0; j < 4; j++) begin
         card_id = 2'(j);
         for (int c = 0; c < 4; c++) begin
            for (int d = 0; d < 8; d++) begin
               logic [7:0] b;
               b = {2'(c), 3'((c*3 + d + j) & 7), 3'(d)};
               send_addr({8'h00, b}, 8);
               xfer("R2 R3 R4 R5 R7 decode sweep", exp_ports(j, c, d), 16'h00A5, 8);
            end
         end
      end

      card_id = 2'd2;
      // R6 repeated transfers on one selection
      send_addr({8'h00, 2'd2, 3'b101, 3'd3}, 8);
      for (int k = 0; k < 3; k++) xfer("R6 persist", 4'b1011, 16'h0033, 8);

      // R8 short and long address phases are discarded
      send_addr({9'h000, 2'd2, 3'b000, 2'd1}, 7);
      xfer("R8 seven bits kept old", 4'b1011, 16'h0000, 8);
      send_addr({7'h00, 1'b0, 2'd2, 3'b000, 3'd1}, 9);
      xfer("R8 nine bits kept old", 4'b1011, 16'h0000, 8);

      // R9 full LED sweep
      send_addr({8'h00, 2'd2, 3'b011, 3'd5}, 8);
      for (int v = 0; v < 256; v++) begin
         xfer("R5 LED code no port", 4'hF, 16'(v), 8);
         led_model = 8'(v);
         chk_leds("R9 LED value");
      end
      xfer("R9 load", 4'hF, 16'h0099, 8);
      led_model = 8'h99;
      chk_leds("R9 load");
      xfer("R9 seven bits", 4'hF, 16'h0066, 7);
      chk_leds("R9 seven bits ignored");
      xfer("R9 nine bits", 4'hF, 16'h0166, 9);
      chk_leds("R9 nine bits ignored");

      // R3 LED write aimed at another card
      send_addr({8'h00, 2'd1, 3'b000, 3'd5}, 8);
      xfer("R3 foreign LED", 4'hF, 16'h0066, 8);
      chk_leds("R3 foreign LED unchanged");

      // R3 jumper change makes a selection foreign
      send_addr({8'h00, 2'd2, 3'b111, 3'd4}, 8);
      xfer("R4 port4", 4'b0111, 16'h0000, 8);
      card_id = 2'd3;
      wt(4);
      xfer("R3 jumper mismatch", 4'hF, 16'h0000, 8);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule